// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block moves outgoing frames from system memory into a transmit byte stream, steered by a ring of buffer descriptors. Each descriptor takes two consecutive words of a descriptor RAM. The first is a status word that carries the frame length and control bits. The second is the byte address of the frame buffer. While transmission is enabled, the engine polls the status word at its current ring index and waits there until software marks the descriptor ready. It then cleans the status bits and works out three frame properties for the downstream framer: the minimum length after padding, the maximum allowed length, and whether a CRC is to be appended.

The frame buffer is read one 32-bit word at a time through a simple request/acknowledge port. Each word is split into bytes, and the bytes go onto a valid/ready stream. Once every byte is out, the engine waits for the downstream side to report success or failure. It then writes the completed status back into the same descriptor slot and pulses the matching interrupt-source flag. It raises the interrupt line if the descriptor and the mask allow it, and it steps the ring index to the next descriptor.

Status word layout: LENGTH bits 31:16, READY 15, IRQ 14, WRAP 13, PAD 12, CRC 11, LAST 10, bit 9 spare (kept as written), UNDERRUN 8, RETRY count 7:4, RETRANSMIT 3, COLLISION 2, DEFER 1, NO-CARRIER 0.

Top module: `txdma_engine`

## Requirements
- R1: After reset the ring index is 0 and `tx_valid`, `mem_req`, `bd_we`, `src_txb`, `src_txe` and `irq` are all low.
- R2: While the status word at the current index has READY (bit 15) clear, the engine issues no memory read and no descriptor write, and it keeps its index.
- R3: When a descriptor is accepted, status bits 8:0 (underrun, retry count, retransmit, collision, defer, no-carrier) are cleared. All other bits are carried unchanged into the written-back word, apart from the changes of R8.
- R4: `frm_min_len` equals `cfg_min_len` when the descriptor PAD bit (12) or `mode_pad` is set, and otherwise equals the descriptor LENGTH.
- R5: `frm_max_len` equals the descriptor LENGTH when `mode_huge` is set, and otherwise equals `cfg_max_len`.
- R6: `frm_add_crc` is high when `mode_crc` is set, or when the descriptor has both CRC (bit 11) and LAST (bit 10) set.
- R7: The buffer is read as aligned words at pointer + 4k. The stream carries exactly LENGTH bytes, each word split most-significant byte first, and `tx_last` marks the final byte only.
- R8: On `tx_done` the engine writes the status back to the current index with READY cleared and pulses `src_txb`. On `tx_fail`, which wins if both are high, it also clears COLLISION (bit 2) and pulses `src_txe`.
- R9: `irq` pulses with the write-back only when the descriptor IRQ bit (14) is set and at least one of `mask_txb` or `mask_txe` is set.
- R10: After write-back the index moves up by 2, or returns to 0 when the descriptor WRAP bit (13) is set or the index is at the last slot (RING_WORDS-2).
- R11: With `tx_enable` low the engine goes idle within one cycle and drives no stream or memory request. It keeps its index and resumes polling from that index when re-enabled.
- R12: A descriptor whose LENGTH is 0 makes no memory read and emits no bytes. It goes straight to waiting for the done or fail return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Transmit enable from the mode register |
| mode_pad | input | 1 | Global pad-short-frames mode bit |
| mode_huge | input | 1 | Global oversized-frame allow bit |
| mode_crc | input | 1 | Global append-CRC bit |
| cfg_min_len | input | 16 | Configured minimum frame length |
| cfg_max_len | input | 16 | Configured maximum frame length |
| mask_txb | input | 1 | Interrupt mask for transmit-done |
| mask_txe | input | 1 | Interrupt mask for transmit-error |
| bd_index | output | IDX_W | Current ring index (word address of the status word) |
| bd_stat_rdata | input | 32 | Descriptor RAM word at `bd_index` |
| bd_ptr_rdata | input | 32 | Descriptor RAM word at `bd_index`+1 |
| bd_we | output | 1 | Write strobe for the status word at `bd_index` |
| bd_wdata | output | 32 | Status word to write back |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` is valid with it |
| mem_rdata | input | 32 | Read data word |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream byte accepted |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| frm_min_len | output | 16 | Minimum length for the current frame |
| frm_max_len | output | 16 | Maximum length for the current frame |
| frm_add_crc | output | 1 | Current frame needs CRC appended |
| tx_done | input | 1 | Downstream reports the frame sent |
| tx_fail | input | 1 | Downstream reports the frame failed |
| src_txb | output | 1 | Pulse: set the transmit-done source flag |
| src_txe | output | 1 | Pulse: set the transmit-error source flag |
| irq | output | 1 | Interrupt pulse |

## Verification
The properties assume that `mem_ack` comes only while `mem_req` is high, and that every buffer pointer placed in a descriptor is word aligned; the alignment property on `mem_addr` depends on it. They also assume that `tx_enable` stays high while a memory read is outstanding. The bench models the memory with an acknowledge that fires one cycle after each request. It writes only aligned pointers and keeps the enable steady during frames, dropping it only while the engine polls a descriptor that is not ready.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
   localparam int LEN_W   = 16;
   localparam int LEN_LSB = 16;

   localparam int ST_READY    = 15;
   localparam int ST_IRQ      = 14;
   localparam int ST_WRAP     = 13;
   localparam int ST_PAD      = 12;
   localparam int ST_CRC      = 11;
   localparam int ST_LAST     = 10;
   localparam int ST_COLL     = 2;

   // bits cleared when a descriptor is taken: underrun, retry[7:4], retransmit, collision, defer, no-carrier
   localparam logic [31:0] ST_ACCEPT_CLR = 32'h0000_01FF;
   localparam logic [31:0] ST_READY_M    = 32'h1 << ST_READY;
   localparam logic [31:0] ST_COLL_M     = 32'h1 << ST_COLL;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_WAIT   = 3'd1,
      S_FETCH  = 3'd2,
      S_UNPACK = 3'd3,
      S_XMIT   = 3'd4
   } tx_state_e;
endpackage

// File: rtl/txdma_desc_decode.sv
module txdma_desc_decode
   import txdma_pkg::*;
(
   input  logic [31:0]      stat,
   input  logic             mode_pad,
   input  logic             mode_huge,
   input  logic             mode_crc,
   input  logic [LEN_W-1:0] cfg_min_len,
   input  logic [LEN_W-1:0] cfg_max_len,
   output logic [LEN_W-1:0] len,
   output logic [LEN_W-1:0] min_len,
   output logic [LEN_W-1:0] max_len,
   output logic             add_crc,
   output logic [31:0]      stat_clean
);
   always_comb begin
      len        = stat[LEN_LSB +: LEN_W];
      min_len    = (stat[ST_PAD] || mode_pad) ? cfg_min_len : len;
      max_len    = mode_huge ? len : cfg_max_len;
      add_crc    = mode_crc || (stat[ST_CRC] && stat[ST_LAST]);
      stat_clean = stat & ~ST_ACCEPT_CLR;
   end
endmodule

// File: rtl/txdma_unpack.sv
module txdma_unpack #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int SEL_W = $clog2(LANES)
) (
   input  logic [LANES*LANE_W-1:0] word,
   input  logic [SEL_W-1:0]        lane,
   output logic [LANE_W-1:0]       byte_o
);
   logic [LANE_W-1:0] lane_arr [LANES];

   // lane 0 is the most significant byte of the word
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_arr[g] = word[(LANES-1-g)*LANE_W +: LANE_W];
   end

   assign byte_o = lane_arr[lane];
endmodule

// File: rtl/txdma_ring_step.sv
module txdma_ring_step #(
   parameter int RING_WORDS = 8,
   parameter int IDX_W      = 3
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             wrap,
   output logic [IDX_W-1:0] nxt
);
   localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(RING_WORDS - 2);

   always_comb begin
      if (wrap || idx >= LAST_SLOT) nxt = '0;
      else                          nxt = idx + IDX_W'(2);
   end
endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
   import txdma_pkg::*;
#(
   parameter int RING_WORDS = 8,
   parameter int ADDR_W     = 32,
   localparam int IDX_W     = (RING_WORDS > 2) ? $clog2(RING_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_enable,
   input  logic              mode_pad,
   input  logic              mode_huge,
   input  logic              mode_crc,
   input  logic [15:0]       cfg_min_len,
   input  logic [15:0]       cfg_max_len,
   input  logic              mask_txb,
   input  logic              mask_txe,
   output logic [IDX_W-1:0]  bd_index,
   input  logic [31:0]       bd_stat_rdata,
   input  logic [31:0]       bd_ptr_rdata,
   output logic              bd_we,
   output logic [31:0]       bd_wdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   output logic [15:0]       frm_min_len,
   output logic [15:0]       frm_max_len,
   output logic              frm_add_crc,
   input  logic              tx_done,
   input  logic              tx_fail,
   output logic              src_txb,
   output logic              src_txe,
   output logic              irq
);
   localparam int LANES = 4;

   if (RING_WORDS < 2 || (RING_WORDS % 2) != 0) begin : g_bad_ring
      $error("txdma_engine: RING_WORDS must be even and at least 2");
   end
   if (ADDR_W <= LEN_W || ADDR_W > 32) begin : g_bad_addr
      $error("txdma_engine: ADDR_W must lie in (LEN_W, 32]");
   end

   tx_state_e         state_q;
   logic [IDX_W-1:0]  idx_q, idx_nxt;
   logic [31:0]       stat_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [LEN_W-1:0]  len_q, cnt_q;
   logic [31:0]       word_q;
   logic [LEN_W-1:0]  min_q, max_q;
   logic              crc_q;

   logic [LEN_W-1:0]  dec_len, dec_min, dec_max;
   logic              dec_crc;
   logic [31:0]       dec_clean;
   logic [31:0]       ptr_word;
   logic              accept, beat, last_beat, fin;

   txdma_desc_decode u_decode (
      .stat        (bd_stat_rdata),
      .mode_pad    (mode_pad),
      .mode_huge   (mode_huge),
      .mode_crc    (mode_crc),
      .cfg_min_len (cfg_min_len),
      .cfg_max_len (cfg_max_len),
      .len         (dec_len),
      .min_len     (dec_min),
      .max_len     (dec_max),
      .add_crc     (dec_crc),
      .stat_clean  (dec_clean)
   );

   txdma_unpack #(.LANES(LANES), .LANE_W(8)) u_unpack (
      .word   (word_q),
      .lane   (cnt_q[1:0]),
      .byte_o (tx_data)
   );

   txdma_ring_step #(.RING_WORDS(RING_WORDS), .IDX_W(IDX_W)) u_ring (
      .idx  (idx_q),
      .wrap (stat_q[ST_WRAP]),
      .nxt  (idx_nxt)
   );

   assign ptr_word  = bd_ptr_rdata;
   assign accept    = (state_q == S_WAIT) && bd_stat_rdata[ST_READY];
   assign beat      = (state_q == S_UNPACK) && tx_ready;
   assign last_beat = (cnt_q + LEN_W'(1)) == len_q;
   assign fin       = (state_q == S_XMIT) && (tx_done || tx_fail);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         stat_q  <= '0;
         ptr_q   <= '0;
         len_q   <= '0;
         cnt_q   <= '0;
         word_q  <= '0;
         min_q   <= '0;
         max_q   <= '0;
         crc_q   <= 1'b0;
      end else if (!tx_enable) begin
         state_q <= S_IDLE;
      end else begin
         unique case (state_q)
            S_IDLE: state_q <= S_WAIT;
            S_WAIT: begin
               if (accept) begin
                  stat_q  <= dec_clean;
                  ptr_q   <= ptr_word[ADDR_W-1:0];
                  len_q   <= dec_len;
                  min_q   <= dec_min;
                  max_q   <= dec_max;
                  crc_q   <= dec_crc;
                  cnt_q   <= '0;
                  state_q <= (dec_len == '0) ? S_XMIT : S_FETCH;
               end
            end
            S_FETCH: begin
               if (mem_ack) begin
                  word_q  <= mem_rdata;
                  state_q <= S_UNPACK;
               end
            end
            S_UNPACK: begin
               if (beat) begin
                  cnt_q <= cnt_q + LEN_W'(1);
                  if (last_beat)              state_q <= S_XMIT;
                  else if (cnt_q[1:0] == 2'd3) state_q <= S_FETCH;
               end
            end
            S_XMIT: begin
               if (fin) begin
                  idx_q   <= idx_nxt;
                  state_q <= S_WAIT;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      bd_index    = idx_q;
      mem_req     = (state_q == S_FETCH);
      mem_addr    = ptr_q + {{(ADDR_W-LEN_W){1'b0}}, cnt_q[LEN_W-1:2], 2'b00};
      tx_valid    = (state_q == S_UNPACK);
      tx_last     = tx_valid && last_beat;
      frm_min_len = min_q;
      frm_max_len = max_q;
      frm_add_crc = crc_q;
      bd_we       = fin;
      bd_wdata    = tx_fail ? (stat_q & ~ST_READY_M & ~ST_COLL_M) : (stat_q & ~ST_READY_M);
      src_txb     = fin && !tx_fail;
      src_txe     = fin && tx_fail;
      irq         = fin && stat_q[ST_IRQ] && (mask_txb || mask_txe);
   end
endmodule

// File: rtl/txdma_engine_chk.sv
module txdma_engine_chk #(
   parameter int RING_WORDS = 8,
   parameter int ADDR_W     = 32,
   localparam int IDX_W     = (RING_WORDS > 2) ? $clog2(RING_WORDS) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_enable,
   input logic [IDX_W-1:0]  bd_index,
   input logic              bd_we,
   input logic [31:0]       bd_wdata,
   input logic              mem_req,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              tx_valid,
   input logic              tx_last,
   input logic              src_txb,
   input logic              src_txe,
   input logic              irq
);
   a_r7_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && tx_enable) |=> (mem_req && $stable(mem_addr)));

   a_r7_last_in_stream: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   a_r8_ready_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      bd_we |-> !bd_wdata[15]);

   a_r8_one_source: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({src_txb, src_txe}));

   a_r8_source_with_write: assert property (@(posedge clk) disable iff (!rst_n)
      (src_txb || src_txe) |-> bd_we);

   a_r9_irq_with_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (src_txb || src_txe));

   a_r10_index_even: assert property (@(posedge clk) disable iff (!rst_n)
      !bd_index[0]);

   a_r10_index_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !bd_we |=> $stable(bd_index));

   a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_enable |=> (!tx_valid && !mem_req));
endmodule

bind txdma_engine txdma_engine_chk #(.RING_WORDS(RING_WORDS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/txdma_engine_tb_top.sv
module txdma_engine_tb_top;
   localparam int RING  = 8;
   localparam int IDX_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic tx_enable = 1'b0, mode_pad = 1'b0, mode_huge = 1'b0, mode_crc = 1'b0;
   logic [15:0] cfg_min_len = 16'd60, cfg_max_len = 16'd1518;
   logic mask_txb = 1'b0, mask_txe = 1'b0;
   logic [IDX_W-1:0] bd_index;
   logic [31:0] bd_stat_rdata, bd_ptr_rdata, bd_wdata;
   logic bd_we, mem_req, mem_ack = 1'b0;
   logic [31:0] mem_addr, mem_rdata;
   logic tx_valid, tx_ready = 1'b1, tx_last, frm_add_crc;
   logic [7:0] tx_data;
   logic [15:0] frm_min_len, frm_max_len;
   logic tx_done = 1'b0, tx_fail = 1'b0;
   logic src_txb, src_txe, irq;

   txdma_engine #(.RING_WORDS(RING), .ADDR_W(32)) dut_i (.*);

   // descriptor RAM model
   logic [31:0] ram [RING];
   logic host_we = 1'b0;
   logic [IDX_W-1:0] host_a = '0;
   logic [31:0] host_d = '0;
   assign bd_stat_rdata = ram[bd_index];
   assign bd_ptr_rdata  = ram[bd_index + IDX_W'(1)];
   always @(posedge clk) begin
      if (bd_we) ram[bd_index] <= bd_wdata;
      else if (host_we) ram[host_a] <= host_d;
   end

   function automatic logic [7:0] mbyte(input logic [31:0] a);
      return (a[7:0] * 8'd7 + 8'd3) ^ a[15:8];
   endfunction

   // memory model: acknowledge one cycle after request
   assign mem_rdata = {mbyte(mem_addr), mbyte(mem_addr + 1), mbyte(mem_addr + 2), mbyte(mem_addr + 3)};
   always @(posedge clk) mem_ack <= mem_req && !mem_ack;

   // stream back-pressure pattern
   int cyc = 0;
   always @(posedge clk) begin
      #2;
      cyc = cyc + 1;
      tx_ready = (cyc % 3) != 1;
   end

   // monitor, sampling mid-cycle
   logic [7:0] cap [64];
   logic       cap_last [64];
   int cap_n = 0, fetch_n = 0, wb_n = 0;
   logic [15:0] c_min, c_max;
   logic c_crc;
   logic [31:0] wb_data;
   logic [IDX_W-1:0] wb_idx;
   logic wb_txb, wb_txe, wb_irq;
   always @(negedge clk) begin
      if (tx_valid && tx_ready && cap_n < 64) begin
         if (cap_n == 0) begin c_min = frm_min_len; c_max = frm_max_len; c_crc = frm_add_crc; end
         cap[cap_n] = tx_data;
         cap_last[cap_n] = tx_last;
         cap_n = cap_n + 1;
      end
      if (mem_req) fetch_n = fetch_n + 1;
      if (bd_we) begin
         wb_n = wb_n + 1; wb_data = bd_wdata; wb_idx = bd_index;
         wb_txb = src_txb; wb_txe = src_txe; wb_irq = irq;
      end
   end

   int errors = 0, checks = 0;
   int exp_idx = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic host_write(input int a, input logic [31:0] d);
      host_a = IDX_W'(a); host_d = d; host_we = 1'b1;
      step();
      host_we = 1'b0;
   endtask

   task automatic run_frame(input int len, input bit irq_b, input bit wrap_b, input bit pad_b,
                            input bit crc_b, input bit last_b, input bit fail, input logic [31:0] ptr);
      logic [31:0] st, exp_wb;
      int nxt;
      bit data_ok, last_ok;
      st = {16'(len), 1'b1, irq_b, wrap_b, pad_b, crc_b, last_b, 1'b1, 9'h1A5};
      cap_n = 0; fetch_n = 0; wb_n = 0;
      host_write(exp_idx + 1, ptr);
      host_write(exp_idx, st);
      while (cap_n < len) step();
      step(); step();
      if (len == 0) chk("R12 no fetch for empty frame", 32'(fetch_n), 32'd0);
      if (fail) tx_fail = 1'b1; else tx_done = 1'b1;
      step();
      tx_fail = 1'b0; tx_done = 1'b0;
      // R7: byte content, order and last marker
      data_ok = (cap_n == len); last_ok = 1'b1;
      for (int k = 0; k < len; k++) begin
         if (cap[k] !== mbyte(ptr + 32'(k))) data_ok = 1'b0;
         if (cap_last[k] !== (k == len - 1)) last_ok = 1'b0;
      end
      chk("R7 byte stream content", {31'd0, data_ok}, 32'd1);
      chk("R7 last marker", {31'd0, last_ok}, 32'd1);
      if (len > 0) begin
         chk("R4 minimum length", {16'd0, c_min}, (pad_b || mode_pad) ? {16'd0, cfg_min_len} : 32'(len));
         chk("R5 maximum length", {16'd0, c_max}, mode_huge ? 32'(len) : {16'd0, cfg_max_len});
         chk("R6 crc append", {31'd0, c_crc}, {31'd0, mode_crc || (crc_b && last_b)});
      end
      exp_wb = st & ~32'h0000_81FF;
      chk("R3 R8 written status", wb_data, exp_wb);
      chk("R8 write slot", 32'(wb_idx), 32'(exp_idx));
      chk("R8 source flags", {30'd0, wb_txb, wb_txe}, fail ? 32'd1 : 32'd2);
      chk("R9 interrupt", {31'd0, wb_irq}, {31'd0, irq_b && (mask_txb || mask_txe)});
      nxt = (wrap_b || exp_idx >= RING - 2) ? 0 : exp_idx + 2;
      chk("R10 next index", 32'(bd_index), 32'(nxt));
      exp_idx = nxt;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < RING; i++) ram[i] = 32'd0;
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 index after reset", 32'(bd_index), 32'd0);
      chk("R1 quiet outputs", {26'd0, tx_valid, mem_req, bd_we, src_txb, src_txe, irq}, 32'd0);
      tx_enable = 1'b1;
      step();
      for (int n = 0; n < 10; n++) begin
         mode_pad  = (n == 5);
         mode_huge = (n % 3) == 1;
         mode_crc  = (n == 8);
         mask_txb  = (n % 2) == 0;
         mask_txe  = (n % 5) == 1;
         run_frame(n, (n % 4) != 3, (n == 3 || n == 7), (n % 3) == 0, (n % 2) == 1,
                   (n % 4) < 2, (n % 3) == 2, 32'h0000_1000 + 32'(n * 64));
      end
      // R2: not-ready descriptor is left alone
      fetch_n = 0; wb_n = 0;
      host_write(exp_idx, 32'h0004_6000);
      repeat (6) step();
      chk("R2 no fetch while not ready", 32'(fetch_n), 32'd0);
      chk("R2 no write while not ready", 32'(wb_n), 32'd0);
      chk("R2 index held", 32'(bd_index), 32'(exp_idx));
      // R11: disable holds index, re-enable resumes there
      tx_enable = 1'b0;
      repeat (5) step();
      chk("R11 index held while off", 32'(bd_index), 32'(exp_idx));
      chk("R11 no stream while off", {31'd0, tx_valid}, 32'd0);
      tx_enable = 1'b1;
      mode_pad = 1'b0; mode_huge = 1'b0; mode_crc = 1'b0; mask_txb = 1'b1; mask_txe = 1'b0;
      run_frame(5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_2F00);
      run_frame(11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_3104);
      finish_run();
   end
endmodule